// File: doc/BRIEF.md
# Direct-mapped instruction cache

This block sits between an instruction fetch unit and the next memory level. It holds 16 KB of instruction lines as 512 lines of 32 bytes, with one line per set. The fetch unit presents the line address of a fetch and gets back the whole 32-byte line. A hit answers in the next cycle. A miss raises a stall and issues one line-fill request downstream. The returned line is written into its set and passed straight on to the fetch unit.

The cache is never written by the processor. Invalidation therefore only clears valid bits and never produces write traffic. A lower-level controller can clear every line at once or clear a single set. Two counters report how many fetches hit and how many missed.

Top module: `icache_dm`

## Requirements
- R1: After reset every line is invalid. `fetch_stall`, `fetch_valid` and `mem_req` are low and both counters are zero. The first fetch to any line misses.
- R2: A byte address splits into the byte offset (bits 4:0), the set index (bits 13:5) and the tag (bits 31:14). `fetch_addr` carries bits 31:5. `mem_addr` is the full byte address of the missing line, with bits 4:0 zero.
- R3: On a miss, `fetch_stall` and `mem_req` rise in the cycle after the request. They stay high with `mem_addr` unchanged up to and including the cycle in which `mem_rvalid` is high.
- R4: In the cycle after `mem_rvalid`, `fetch_valid` is high, `fetch_line` equals the returned `mem_rdata`, and `fetch_stall` and `mem_req` are low.
- R5: A hit raises `fetch_valid` in the cycle after the request, with the stored line on `fetch_line`, and raises neither `fetch_stall` nor `mem_req`.
- R6: Two addresses with the same set index and different tags (0x20 and 0x4020) evict each other. Each access that alternates between them misses.
- R7: Any two addresses within one held line, such as 0x20 and 0x3C, hit on the same stored line.
- R8: A one-cycle `inv_all` pulse makes the next fetch to every previously held line miss.
- R9: A one-cycle `inv_line` pulse invalidates only the set given on `inv_set`. Lines in other sets still hit.
- R10: An invalidate that covers the set being filled, arriving while the fill is outstanding, still lets the fill data be forwarded. It leaves that line invalid, so the next fetch to it misses. An invalidate of a different set during a fill leaves the filled line valid.
- R11: `fetch_req` is ignored while `fetch_stall` is high. It starts no fill, changes no counter and gets no response.
- R12: `hit_count` rises by one for each hit and `miss_count` by one for each miss, counted in the cycle after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Fetch request, taken when `fetch_stall` is low |
| fetch_addr | input | 27 | Line address of the fetch (byte address bits 31:5) |
| fetch_stall | output | 1 | High while a miss is outstanding |
| fetch_valid | output | 1 | One-cycle response strobe |
| fetch_line | output | 256 | Returned 32-byte line |
| mem_req | output | 1 | Line-fill request, held until data returns |
| mem_addr | output | 32 | Byte address of the line being filled, offset bits zero |
| mem_rvalid | input | 1 | Fill data valid, one cycle |
| mem_rdata | input | 256 | Fill data |
| inv_all | input | 1 | Invalidate every line |
| inv_line | input | 1 | Invalidate the set on `inv_set` |
| inv_set | input | 9 | Set index to invalidate |
| hit_count | output | 32 | Number of hits |
| miss_count | output | 32 | Number of misses |

## Verification
A valid bit left set when it should be clear shows up at the ports at once, on the next fetch to that set. That fetch answers a cycle after the request with stale data, where `mem_req` should have risen instead. A stored tag or data word written to the wrong set also appears on the first re-fetch of the affected line. The conflict pair, the invalidate-during-fill cases and the line at set 511 force those re-fetches. A fault in the fill state machine shows in the same miss: either `fetch_stall` falls before data returns, or a request sent while stalled starts a second fill.

// File: rtl/ic_pkg.sv
package ic_pkg;
    parameter int ADDR_W     = 32;
    parameter int LINE_BYTES = 32;
    parameter int SETS       = 512;
    parameter int CNT_W      = 32;

    localparam int OFS_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFS_W;
    localparam int LA_W   = ADDR_W - OFS_W;
    localparam int LINE_W = LINE_BYTES * 8;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] idx;
    } laddr_t;

    typedef enum logic [0:0] {ST_IDLE, ST_FILL} fill_state_t;

    function automatic logic [ADDR_W-1:0] line_base(input laddr_t a);
        return {a, {OFS_W{1'b0}}};
    endfunction
endpackage

// File: rtl/ic_tag_store.sv
module ic_tag_store import ic_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_valid,
    input  logic             inv_all,
    input  logic             inv_one,
    input  logic [IDX_W-1:0] inv_idx
);
    logic [TAG_W-1:0] tags [SETS];
    logic [SETS-1:0]  valid;

    always_ff @(posedge clk) begin
        if (wr_en) tags[wr_idx] <= wr_tag;
    end

    // Invalidates are ordered after the fill write so a same-cycle kill wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= '0;
        end else begin
            if (wr_en) valid[wr_idx] <= wr_valid;
            if (inv_all) valid <= '0;
            else if (inv_one) valid[inv_idx] <= 1'b0;
        end
    end

    assign rd_tag   = tags[rd_idx];
    assign rd_valid = valid[rd_idx];
endmodule

// File: rtl/ic_data_store.sv
module ic_data_store import ic_pkg::*; (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LINE_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_data
);
    logic [LINE_W-1:0] lines [SETS];

    always_ff @(posedge clk) begin
        if (wr_en) lines[wr_idx] <= wr_data;
    end

    assign rd_data = lines[rd_idx];
endmodule

// File: rtl/ic_fill_ctrl.sv
module ic_fill_ctrl import ic_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  laddr_t           start_a,
    input  logic             mem_rvalid,
    input  logic             inv_all,
    input  logic             inv_one,
    input  logic [IDX_W-1:0] inv_idx,
    output logic             busy,
    output laddr_t           fill_a,
    output logic             fill_done,
    output logic             fill_keep
);
    fill_state_t state;
    logic        kill;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            kill   <= 1'b0;
            fill_a <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    state  <= ST_FILL;
                    fill_a <= start_a;
                    kill   <= 1'b0;
                end
                ST_FILL: begin
                    if (inv_all || (inv_one && inv_idx == fill_a.idx)) kill <= 1'b1;
                    if (mem_rvalid) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state == ST_FILL);
    assign fill_done = busy && mem_rvalid;
    assign fill_keep = !kill;
endmodule

// File: rtl/icache_dm.sv
module icache_dm import ic_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:OFS_W] fetch_addr,
    output logic              fetch_stall,
    output logic              fetch_valid,
    output logic [LINE_W-1:0] fetch_line,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [LINE_W-1:0] mem_rdata,
    input  logic              inv_all,
    input  logic              inv_line,
    input  logic [IDX_W-1:0]  inv_set,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    laddr_t            req_a, fill_a;
    logic              busy, accept, hit, miss;
    logic [TAG_W-1:0]  rd_tag;
    logic              rd_valid;
    logic [LINE_W-1:0] rd_data;
    logic              fill_done, fill_keep;

    assign req_a  = laddr_t'(fetch_addr);
    assign accept = fetch_req && !busy;
    assign hit    = accept && rd_valid && (rd_tag == req_a.tag);
    assign miss   = accept && !hit;

    ic_tag_store u_tags (
        .clk(clk), .rst(rst),
        .rd_idx(req_a.idx), .rd_tag(rd_tag), .rd_valid(rd_valid),
        .wr_en(fill_done), .wr_idx(fill_a.idx), .wr_tag(fill_a.tag), .wr_valid(fill_keep),
        .inv_all(inv_all), .inv_one(inv_line), .inv_idx(inv_set)
    );

    ic_data_store u_data (
        .clk(clk),
        .rd_idx(req_a.idx), .rd_data(rd_data),
        .wr_en(fill_done), .wr_idx(fill_a.idx), .wr_data(mem_rdata)
    );

    ic_fill_ctrl u_fill (
        .clk(clk), .rst(rst),
        .start(miss), .start_a(req_a), .mem_rvalid(mem_rvalid),
        .inv_all(inv_all), .inv_one(inv_line), .inv_idx(inv_set),
        .busy(busy), .fill_a(fill_a), .fill_done(fill_done), .fill_keep(fill_keep)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_valid <= 1'b0;
            fetch_line  <= '0;
            hit_count   <= '0;
            miss_count  <= '0;
        end else begin
            fetch_valid <= hit || fill_done;
            if (hit)       fetch_line <= rd_data;
            if (fill_done) fetch_line <= mem_rdata;
            if (hit)  hit_count  <= hit_count + 1'b1;
            if (miss) miss_count <= miss_count + 1'b1;
        end
    end

    assign fetch_stall = busy;
    assign mem_req     = busy;
    assign mem_addr    = line_base(fill_a);
endmodule

// File: rtl/icache_dm_chk.sv
module icache_dm_chk import ic_pkg::*; (
    input logic              clk,
    input logic              rst,
    input logic              fetch_req,
    input logic              fetch_stall,
    input logic              fetch_valid,
    input logic [LINE_W-1:0] fetch_line,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rvalid,
    input logic [LINE_W-1:0] mem_rdata,
    input logic [CNT_W-1:0]  hit_count,
    input logic [CNT_W-1:0]  miss_count
);
    p_line_aligned_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[OFS_W-1:0] == '0));

    p_fill_held_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && fetch_stall && $stable(mem_addr)));

    p_miss_stalls_r3: assert property (@(posedge clk) disable iff (rst)
        (miss_count != $past(miss_count)) |-> (fetch_stall && mem_req));

    p_forward_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_rvalid) |=> (fetch_valid && !fetch_stall && fetch_line == $past(mem_rdata)));

    p_answered_r5: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !fetch_stall) |=> (fetch_valid || fetch_stall));

    p_stalled_req_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (fetch_stall && !mem_rvalid) |=> !fetch_valid);

    p_count_step_r12: assert property (@(posedge clk) disable iff (rst)
        ((hit_count - $past(hit_count)) + (miss_count - $past(miss_count))) <= 1);
endmodule

bind icache_dm icache_dm_chk u_chk (
    .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_stall(fetch_stall),
    .fetch_valid(fetch_valid), .fetch_line(fetch_line), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/tb_icache_dm.sv
`timescale 1ns/1ps
module tb_icache_dm;
    import ic_pkg::*;

    localparam int LAT = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              fetch_req = 1'b0;
    logic [ADDR_W-1:OFS_W] fetch_addr = '0;
    logic              fetch_stall, fetch_valid;
    logic [LINE_W-1:0] fetch_line;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rvalid = 1'b0;
    logic [LINE_W-1:0] mem_rdata = '0;
    logic              inv_all = 1'b0, inv_line = 1'b0;
    logic [IDX_W-1:0]  inv_set = '0;
    logic [CNT_W-1:0]  hit_count, miss_count;

    int nvec = 0, nfail = 0;
    int exp_hits = 0, exp_misses = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    icache_dm dut (
        .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_stall(fetch_stall), .fetch_valid(fetch_valid), .fetch_line(fetch_line),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .inv_all(inv_all), .inv_line(inv_line), .inv_set(inv_set),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic        hit;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{32'h0000_0020, 1'b0}, '{32'h0000_0020, 1'b1}, '{32'h0000_003C, 1'b1},
        '{32'h0000_4020, 1'b0}, '{32'h0000_0020, 1'b0}, '{32'h0000_0000, 1'b0},
        '{32'h0000_3FE0, 1'b0}, '{32'h0000_3FFF, 1'b1}, '{32'h0000_0000, 1'b1},
        '{32'h0000_0020, 1'b1}
    };

    function automatic logic [LINE_W-1:0] pat(input logic [ADDR_W-1:0] a);
        logic [LINE_W-1:0] r;
        for (int k = 0; k < LINE_W / 32; k++)
            r[k*32 +: 32] = ({a[ADDR_W-1:OFS_W], 5'b0} * 32'h9E37) ^ (k * 32'h0101_0101) ^ 32'hC0DE_0000;
        return r;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] expv);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
        end
    endtask

    // inj: 0 none, 1 inv_line of ia's set, 2 inv_all, 3 stray fetch of ia, applied during the fill
    task automatic fetch(input logic [31:0] a, input bit exp_hit, input int inj,
                         input logic [31:0] ia, input string rq);
        logic [ADDR_W-1:0] base;
        base = {a[31:5], 5'b0};
        @(negedge clk);
        fetch_req  = 1'b1;
        fetch_addr = a[31:5];
        @(negedge clk);
        fetch_req = 1'b0;
        if (exp_hit) begin
            exp_hits++;
            chk(fetch_valid && !fetch_stall && !mem_req, rq, "hit answers next cycle",
                {fetch_valid, fetch_stall, mem_req}, 3'b100);
            chk(fetch_line == pat(base), rq, "hit line", fetch_line, pat(base));
        end else begin
            exp_misses++;
            chk(fetch_stall && mem_req && !fetch_valid, "R3", "miss stalls and requests",
                {fetch_valid, fetch_stall, mem_req}, 3'b011);
            chk(mem_addr == base, "R2", "fill address", mem_addr, base);
            if (inj == 1) begin inv_line = 1'b1; inv_set = ia[13:5]; end
            if (inj == 2) inv_all = 1'b1;
            if (inj == 3) begin fetch_req = 1'b1; fetch_addr = ia[31:5]; end
            for (int i = 0; i < LAT; i++) begin
                @(negedge clk);
                inv_line = 1'b0; inv_all = 1'b0; fetch_req = 1'b0;
                chk(fetch_stall && mem_req && mem_addr == base && !fetch_valid, "R3",
                    "held during fill", mem_addr, base);
            end
            mem_rvalid = 1'b1;
            mem_rdata  = pat(base);
            @(negedge clk);
            mem_rvalid = 1'b0;
            mem_rdata  = '0;
            chk(fetch_valid && !fetch_stall && !mem_req, "R4", "fill response flags",
                {fetch_valid, fetch_stall, mem_req}, 3'b100);
            chk(fetch_line == pat(base), "R4", "forwarded line", fetch_line, pat(base));
        end
        @(negedge clk);
        chk(!fetch_valid, rq, "single response", fetch_valid, 1'b0);
        chk(hit_count == CNT_W'(exp_hits) && miss_count == CNT_W'(exp_misses), "R12",
            "counters", {hit_count, miss_count}, {CNT_W'(exp_hits), CNT_W'(exp_misses)});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!fetch_stall && !fetch_valid && !mem_req, "R1", "idle after reset",
            {fetch_stall, fetch_valid, mem_req}, 3'b000);
        chk(hit_count == 0 && miss_count == 0, "R1", "counters cleared",
            {hit_count, miss_count}, '0);

        // table walk: R1 compulsory misses, R5 hits, R6 conflict pair, R7 same line
        for (int v = 0; v < 10; v++)
            fetch(VEC[v].addr, VEC[v].hit, 0, 32'h0, VEC[v].hit ? "R5/R7" : "R1/R6");

        // R8 invalidate all
        @(negedge clk); inv_all = 1'b1;
        @(negedge clk); inv_all = 1'b0;
        fetch(32'h0000_0020, 1'b0, 0, 32'h0, "R8");
        fetch(32'h0000_3FE0, 1'b0, 0, 32'h0, "R8");

        // R9 single-set invalidate
        @(negedge clk); inv_line = 1'b1; inv_set = 9'd511;
        @(negedge clk); inv_line = 1'b0;
        fetch(32'h0000_3FE0, 1'b0, 0, 32'h0, "R9");
        fetch(32'h0000_0020, 1'b1, 0, 32'h0, "R9");

        // R10 invalidate during fill
        fetch(32'h0000_0040, 1'b0, 1, 32'h0000_0040, "R10");
        fetch(32'h0000_0040, 1'b0, 0, 32'h0, "R10");
        fetch(32'h0000_0040, 1'b1, 0, 32'h0, "R10");
        fetch(32'h0000_0060, 1'b0, 1, 32'h0000_0020, "R10");
        fetch(32'h0000_0060, 1'b1, 0, 32'h0, "R10");
        fetch(32'h0000_0020, 1'b0, 0, 32'h0, "R10");
        fetch(32'h0000_0080, 1'b0, 2, 32'h0, "R10");
        fetch(32'h0000_0080, 1'b0, 0, 32'h0, "R10");
        fetch(32'h0000_0040, 1'b0, 0, 32'h0, "R10");

        // R11 request while stalled is dropped
        fetch(32'h0000_00A0, 1'b0, 3, 32'h0000_0C00, "R11");
        fetch(32'h0000_00A0, 1'b1, 0, 32'h0, "R11");
        fetch(32'h0000_0C00, 1'b0, 0, 32'h0, "R11");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end
endmodule